// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Logic

This block is the digital core of a small serial non-volatile memory with a chip select, a shift clock, a serial input and a serial output that can be turned off. It holds 4 kbit of storage in registers. A static organization pin selects either 256 words of 16 bits or 512 bytes. A host selects the block, clocks in a start bit, a two-bit opcode and an address, and then either receives data or sends a data word to be programmed. Programming commands take effect only while a software-controlled enable latch is set. Every program operation runs a self-timed cycle whose length is the parameter `WRITE_CYCLES`, counted on the system clock. While that cycle runs, the output pin reports busy or ready.

The chip select, shift clock and data input arrive asynchronously. They are brought into the system clock domain through a parameterised synchronizer, and each shift clock rising edge is detected in that domain. The port has no flow control. The host sets the pace of every bit with the shift clock, and the block accepts or delivers exactly one bit on each rising edge.

Top module: `sere_core`

## Requirements
- R1: With `org_wide` high the array is 256 words of 16 bits and the address field is 8 bits. With `org_wide` low it is 512 bytes and the address field is 9 bits. Word n in the wide mode occupies byte 2n (high half) and byte 2n+1 (low half).
- R2: An instruction starts with the first rising shift clock edge, while chip select is high, at which the input is 1. Zeros before that edge are ignored. The opcode (2 bits), the address and the write data follow, all sampled on rising edges with the MSB first.
- R3: Opcode 10 reads, 01 writes one location and 11 erases one location. For opcode 00, the two most significant address bits select the command: 11 sets the enable latch, 00 clears it, 10 erases the whole array, and 01 writes one data word to every location. The other address bits are don't-care but must still be clocked.
- R4: After the last address bit of a read, the output drives a single 0, then the data MSB first, with one new bit per rising shift clock edge.
- R5: While chip select stays high, a read continues with the next address and no extra 0 between words. The address wraps from the last location to location 0.
- R6: The enable latch is clear after reset and changes only on the set and clear commands. While it is clear, write, erase, erase-all and write-all leave the array unchanged and start no program cycle.
- R7: Reads work whether the enable latch is set or clear.
- R8: Erase and erase-all set the targeted bits to 1. A write stores its data whatever the location held before. Write-all stores the same word in every location.
- R9: A program cycle starts right after its last bit and lasts `WRITE_CYCLES` clock cycles. Once chip select has been taken low and raised again, the output shows 0 while the cycle runs and 1 after it ends. The next accepted start bit removes this status.
- R10: The output enable is low whenever chip select is low.
- R11: A start bit that arrives during a program cycle is ignored, and the busy status remains on the output.
- R12: After reset every bit of the array reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| org_wide | input | 1 | Static organization select: 1 = 16-bit words, 0 = bytes |
| cs | input | 1 | Chip select, active high, asynchronous |
| sk | input | 1 | Serial shift clock from the host, asynchronous |
| din | input | 1 | Serial data input, sampled on rising sk |
| dout | output | 1 | Serial data or ready/busy status |
| dout_en | output | 1 | Output driver enable for dout (low = high impedance) |

## Verification
Any result caused by a rising shift clock edge appears at the output about three system clocks later: two synchronizer stages plus the edge-detect register. The bench holds each shift clock phase for eight clocks and samples the output just before the next rising edge, after that result has settled. Busy is sampled about twenty clocks after the launching edge, which is well inside the shortened program time. Ready is sampled `WRITE_CYCLES` plus twenty clocks after launch. A behavioural byte-array model predicts every read bit and the status. Once chip select has been low for four clocks, the output enable is compared against zero on every clock.

// File: rtl/sere_pkg.sv
package sere_pkg;
  typedef enum logic [1:0] {
    PK_WR_ONE = 2'd0,
    PK_ER_ONE = 2'd1,
    PK_WR_ALL = 2'd2,
    PK_ER_ALL = 2'd3
  } pkind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_DATA = 3'd2,
    ST_READ = 3'd3,
    ST_HOLD = 3'd4
  } st_t;
endpackage

// File: rtl/sere_sync.sv
module sere_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d_in;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign d_out = pipe[STAGES-1];
endmodule

// File: rtl/sere_array.sv
module sere_array
  import sere_pkg::*;
#(
  parameter int ADDR_BITS    = 9,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 org_wide,
  input  logic [ADDR_BITS-1:0] rd_addr,
  output logic [15:0]          rd_word,
  input  logic                 go,
  input  pkind_t               kind,
  input  logic [ADDR_BITS-1:0] pg_addr,
  input  logic [15:0]          pg_data,
  output logic                 busy
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int TW    = $clog2(WRITE_CYCLES + 1);

  logic [7:0]           mem [DEPTH];
  logic [TW-1:0]        tmr;
  pkind_t               j_kind;
  logic [ADDR_BITS-1:0] j_addr;
  logic [15:0]          j_data;
  logic                 j_org;
  logic                 commit;

  assign busy   = (tmr != '0);
  assign commit = (tmr == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr    <= '0;
      j_kind <= PK_WR_ONE;
      j_addr <= '0;
      j_data <= '0;
      j_org  <= 1'b0;
    end else if (go) begin
      tmr    <= TW'(WRITE_CYCLES);
      j_kind <= kind;
      j_addr <= pg_addr;
      j_data <= pg_data;
      j_org  <= org_wide;
    end else if (busy) begin
      tmr <= tmr - TW'(1);
    end
  end

  // Whole-array commit at the end of the timed cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [ADDR_BITS-1:0] idx;
        logic                 hit;
        idx = ADDR_BITS'(i);
        hit = (j_kind == PK_WR_ALL) || (j_kind == PK_ER_ALL) ||
              (j_org ? (j_addr[ADDR_BITS-2:0] == idx[ADDR_BITS-1:1]) : (j_addr == idx));
        if (hit) begin
          if (j_kind == PK_ER_ONE || j_kind == PK_ER_ALL) mem[i] <= 8'hFF;
          else if (j_org) mem[i] <= idx[0] ? j_data[7:0] : j_data[15:8];
          else mem[i] <= j_data[7:0];
        end
      end
    end
  end

  always_comb begin
    if (org_wide)
      rd_word = {mem[{rd_addr[ADDR_BITS-2:0], 1'b0}], mem[{rd_addr[ADDR_BITS-2:0], 1'b1}]};
    else
      rd_word = {8'h00, mem[rd_addr]};
  end

  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R11
  AST_BUSY_FROM_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go)); // R9
  AST_MEM_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[0] != $past(mem[0])) |-> $past(busy)); // R8
endmodule

// File: rtl/sere_ctrl.sv
module sere_ctrl
  import sere_pkg::*;
#(
  parameter int ADDR_BITS = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 org_wide,
  input  logic                 cs_s,
  input  logic                 sk_s,
  input  logic                 din_s,
  input  logic                 busy,
  input  logic [15:0]          rd_word,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic                 go,
  output pkind_t               kind,
  output logic [ADDR_BITS-1:0] pg_addr,
  output logic [15:0]          pg_data,
  output logic                 dout,
  output logic                 dout_en
);
  localparam int SRW = ADDR_BITS + 2;
  localparam int CW  = 5;

  st_t                  st;
  logic                 sk_d, sk_rise;
  logic [CW-1:0]        cnt, cnt_inc, cmd_len, dw;
  logic [3:0]           aw, bit_idx;
  logic [SRW-1:0]       sr, sr_n;
  logic [15:0]          dsr, dsr_n;
  logic [ADDR_BITS-1:0] addr, amask, a_n;
  logic [1:0]           op, sub;
  logic                 en_q, stat_pend, dout_q;
  pkind_t               pend_kind;

  assign sk_rise = sk_s & ~sk_d;
  assign aw      = org_wide ? 4'(ADDR_BITS - 1) : 4'(ADDR_BITS);
  assign dw      = org_wide ? CW'(16) : CW'(8);
  assign cmd_len = CW'(aw) + CW'(2);
  assign cnt_inc = cnt + CW'(1);
  assign sr_n    = {sr[SRW-2:0], din_s};
  assign dsr_n   = {dsr[14:0], din_s};
  assign op      = 2'(sr_n >> aw);
  assign sub     = 2'(sr_n >> (aw - 4'd2));
  assign amask   = org_wide ? {1'b0, {(ADDR_BITS-1){1'b1}}} : {ADDR_BITS{1'b1}};
  assign a_n     = sr_n[ADDR_BITS-1:0] & amask;
  assign bit_idx = 4'(dw - CW'(1) - cnt);
  assign rd_addr = addr;
  assign pg_addr = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sk_d      <= 1'b0;
      cnt       <= '0;
      sr        <= '0;
      dsr       <= '0;
      addr      <= '0;
      en_q      <= 1'b0;
      stat_pend <= 1'b0;
      dout_q    <= 1'b0;
      pend_kind <= PK_WR_ONE;
      go        <= 1'b0;
      kind      <= PK_WR_ONE;
      pg_data   <= '0;
    end else begin
      sk_d <= sk_s;
      go   <= 1'b0;
      if (!cs_s) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else if (sk_rise) begin
        unique case (st)
          ST_IDLE: if (din_s && !busy) begin
            st        <= ST_CMD;
            cnt       <= '0;
            sr        <= '0;
            stat_pend <= 1'b0;
          end
          ST_CMD: begin
            sr  <= sr_n;
            cnt <= cnt_inc;
            if (cnt_inc == cmd_len) begin
              cnt  <= '0;
              addr <= a_n;
              st   <= ST_HOLD;
              unique case (op)
                2'b10: begin st <= ST_READ; dout_q <= 1'b0; end
                2'b01: begin st <= ST_DATA; pend_kind <= PK_WR_ONE; end
                2'b11: if (en_q) begin go <= 1'b1; kind <= PK_ER_ONE; stat_pend <= 1'b1; end
                default: unique case (sub)
                  2'b11: en_q <= 1'b1;
                  2'b00: en_q <= 1'b0;
                  2'b10: if (en_q) begin go <= 1'b1; kind <= PK_ER_ALL; stat_pend <= 1'b1; end
                  default: begin st <= ST_DATA; pend_kind <= PK_WR_ALL; end
                endcase
              endcase
            end
          end
          ST_DATA: begin
            dsr <= dsr_n;
            cnt <= cnt_inc;
            if (cnt_inc == dw) begin
              cnt     <= '0;
              st      <= ST_HOLD;
              pg_data <= dsr_n;
              if (en_q) begin go <= 1'b1; kind <= pend_kind; stat_pend <= 1'b1; end
            end
          end
          ST_READ: begin
            dout_q <= rd_word[bit_idx];
            if (cnt_inc == dw) begin
              cnt  <= '0;
              addr <= (addr + ADDR_BITS'(1)) & amask;
            end else begin
              cnt <= cnt_inc;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dout_en = cs_s && ((st == ST_READ) || (st == ST_IDLE && stat_pend));
  assign dout    = (st == ST_READ) ? dout_q : !busy;

  AST_EN_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> $past(sk_rise)); // R6
  AST_GO_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(en_q)); // R6
endmodule

// File: rtl/sere_core.sv
module sere_core
  import sere_pkg::*;
#(
  parameter int ADDR_BITS    = 9,
  parameter int WRITE_CYCLES = 5000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_wide,
  input  logic cs,
  input  logic sk,
  input  logic din,
  output logic dout,
  output logic dout_en
);
  logic [2:0]           pins_s;
  logic                 busy, go;
  logic [15:0]          rd_word, pg_data;
  logic [ADDR_BITS-1:0] rd_addr, pg_addr;
  pkind_t               kind;

  sere_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in({cs, sk, din}), .d_out(pins_s)
  );

  sere_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .org_wide(org_wide),
    .cs_s(pins_s[2]), .sk_s(pins_s[1]), .din_s(pins_s[0]),
    .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr),
    .go(go), .kind(kind), .pg_addr(pg_addr), .pg_data(pg_data),
    .dout(dout), .dout_en(dout_en)
  );

  sere_array #(.ADDR_BITS(ADDR_BITS), .WRITE_CYCLES(WRITE_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .org_wide(org_wide),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .go(go), .kind(kind), .pg_addr(pg_addr), .pg_data(pg_data),
    .busy(busy)
  );

  AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!pins_s[2] && !$past(pins_s[2])) |-> !dout_en); // R10
endmodule

// File: tb/sere_core_tb.sv
module sere_core_tb_top;
  localparam int CLK_P = 10;
  localparam int WC    = 100;

  logic clk = 0, rst_n = 0, org_wide = 1, cs = 0, sk = 0, din = 0;
  logic dout, dout_en;
  int   n_cmp = 0, n_bad = 0, cyc = 0, cs_low_run = 0;
  int   aw = 8, dw = 16;
  logic [7:0] m [512];

  always #(CLK_P/2) clk = ~clk;

  sere_core #(.ADDR_BITS(9), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cs(cs), .sk(sk),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10: every clock, once cs has been low for 4 clocks, the driver is off
  always @(negedge clk) begin
    if (rst_n && !cs) cs_low_run++; else cs_low_run = 0;
    if (cs_low_run >= 4) chk("R10 dout_en while deselected", {31'b0, dout_en}, 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic set_org(input logic w);
    org_wide = w; aw = w ? 8 : 9; dw = w ? 16 : 8;
  endtask
  task automatic cs_on();  @(negedge clk); cs = 1; repeat (4) @(negedge clk); endtask
  task automatic cs_off(); @(negedge clk); cs = 0; din = 0; repeat (4) @(negedge clk); endtask
  task automatic clock_bit(input logic b);
    @(negedge clk); din = b;
    repeat (3) @(negedge clk); sk = 1;
    repeat (8) @(negedge clk); sk = 0;
    repeat (8) @(negedge clk);
  endtask
  task automatic cmd(input logic [1:0] op, input logic [8:0] a);
    clock_bit(1); clock_bit(op[1]); clock_bit(op[0]);
    for (int i = aw - 1; i >= 0; i--) clock_bit(a[i]);
  endtask
  task automatic send_data(input logic [15:0] d);
    for (int i = dw - 1; i >= 0; i--) clock_bit(d[i]);
  endtask
  function automatic logic [8:0] sub_addr(input logic [1:0] s);
    return (aw == 8) ? {1'b0, s, 6'b0} : {s, 7'b0};
  endfunction
  function automatic logic [15:0] exp_word(input int a);
    return (dw == 16) ? {m[2*a], m[2*a+1]} : {8'h00, m[a]};
  endfunction
  task automatic model_write(input int a, input logic [15:0] d);
    if (dw == 16) begin m[2*a] = d[15:8]; m[2*a+1] = d[7:0]; end
    else m[a] = d[7:0];
  endtask

  task automatic read_check(input string tag, input int a, input int nw, input int lead);
    int addr = a;
    cs_on();
    for (int i = 0; i < lead; i++) clock_bit(0);
    cmd(2'b10, 9'(a));
    chk({tag, " R4 dummy zero"}, {30'b0, dout_en, dout}, 32'h2);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] e = exp_word(addr);
      for (int b = dw - 1; b >= 0; b--) begin
        clock_bit(0);
        chk($sformatf("%s R5 word %0d bit %0d", tag, w, b), {31'b0, dout}, {31'b0, e[b]});
      end
      addr = (addr + 1) % ((dw == 16) ? 256 : 512);
    end
    cs_off();
  endtask

  task automatic wait_ready(input string tag);
    cs_off(); cs_on();
    chk({tag, " R9 busy"}, {30'b0, dout_en, dout}, 32'h2);
    repeat (WC + 20) @(negedge clk);
    chk({tag, " R9 ready"}, {30'b0, dout_en, dout}, 32'h3);
    cs_off();
  endtask

  task automatic no_status(input string tag);
    cs_off(); cs_on();
    chk({tag, " R6 no program cycle"}, {31'b0, dout_en}, 0);
    cs_off();
  endtask

  initial begin
    for (int i = 0; i < 512; i++) m[i] = 8'hFF;
    repeat (5) @(negedge clk);
    chk("R10 reset dout_en", {31'b0, dout_en}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    set_org(1);

    read_check("R12 R7 reset contents", 0, 1, 0);

    // R6: write with the latch clear is ignored
    cs_on(); cmd(2'b01, 5); send_data(16'h1234);
    no_status("R6 disabled write");
    read_check("R6 disabled write readback", 5, 1, 0);

    // R3 enable, R8 write, R1 wide mapping
    cs_on(); cmd(2'b00, sub_addr(2'b11)); cs_off();
    cs_on(); cmd(2'b01, 5); send_data(16'hA55A);
    wait_ready("R8 write");
    model_write(5, 16'hA55A);
    read_check("R8 R5 two words", 5, 2, 0);

    // R11: start bit during busy is ignored
    cs_on(); cmd(2'b01, 6); send_data(16'h0F0F);
    cs_off(); cs_on();
    clock_bit(1);
    chk("R11 start while busy", {30'b0, dout_en, dout}, 32'h2);
    repeat (WC + 20) @(negedge clk);
    chk("R11 R9 ready after", {30'b0, dout_en, dout}, 32'h3);
    cs_off();
    model_write(6, 16'h0F0F);
    read_check("R2 leading zeros", 6, 1, 3);

    // R1 byte mode
    set_org(0);
    cs_on(); cmd(2'b01, 11); send_data(16'h003C);
    wait_ready("R1 byte write");
    model_write(11, 16'h003C);
    read_check("R1 byte read", 10, 2, 0);

    cs_on(); cmd(2'b01, 511); send_data(16'h0077);
    wait_ready("R5 last byte");
    model_write(511, 16'h0077);
    read_check("R5 wrap bytes", 511, 2, 0);

    // R8 erase one word
    set_org(1);
    cs_on(); cmd(2'b11, 5);
    wait_ready("R8 erase");
    model_write(5, 16'hFFFF);
    read_check("R8 erased", 5, 1, 0);

    // R8 write all
    cs_on(); cmd(2'b00, sub_addr(2'b01)); send_data(16'hC3E1);
    wait_ready("R8 write all");
    for (int i = 0; i < 256; i++) model_write(i, 16'hC3E1);
    read_check("R8 R5 write all wrap", 255, 2, 0);

    // R8 erase all
    cs_on(); cmd(2'b00, sub_addr(2'b10));
    wait_ready("R8 erase all");
    for (int i = 0; i < 512; i++) m[i] = 8'hFF;
    read_check("R8 erase all", 3, 1, 0);

    // R6 disable, then programming is ignored; R7 read still works
    cs_on(); cmd(2'b00, sub_addr(2'b00)); cs_off();
    cs_on(); cmd(2'b01, 7); send_data(16'h1111);
    no_status("R6 after disable");
    read_check("R6 R7 disabled readback", 7, 1, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule